// File: doc/BRIEF.md
# Serial ADC Slave Interface Emulator

This block stands in for the digital side of a 12-bit serial analog-to-digital converter. A host drives an active-low select (`cs_n`) and a serial clock (`sclk`). The block answers with a 16-bit frame on a serial data line that has a separate output enable, so an external pad can three-state it. The frame is four zero bits followed by a 12-bit sample word, most significant bit first. The sample word comes from a parallel input instead of an analog front end.

Both host inputs are sampled on the block's system clock, which must run well above the serial clock rate. The block counts falling edges of `sclk` inside each frame. When `cs_n` returns high, that count decides the next power mode: stay running, drop to sleep, or finish waking up. The mode and a data-valid flag for the current frame appear on status outputs. No analog circuitry is modelled.

Top module: `serial_adc_slave`

## Requirements
- R1: After a sampled `cs_n` falling edge, `sdata` shows bit 15 of the frame on the next clock. Bits 15..12 are zero and bits 11..0 are the sample word, MSB first. Each later sampled `sclk` falling edge while `cs_n` is low advances one bit. After all 16 bits have gone out, `sdata` is 0.
- R2: `sdata_oe` is 1 from the clock after a sampled `cs_n` fall until the clock after the sampled `cs_n` rise, and 0 otherwise. This holds when a frame is aborted too. `sdata` is 0 whenever `sdata_oe` is 0.
- R3: The sample word is captured on the clock that detects the `cs_n` fall. Later changes to `sample` do not alter the frame in progress.
- R4: `mode` is encoded 2'b00 running, 2'b01 sleep, 2'b10 waking. The value 2'b11 never appears. After reset, `mode` is 2'b00 and `sdata_oe` and `data_valid` are 0.
- R5: In running mode, a frame ended with fewer than 2 `sclk` falling edges leaves the mode at running.
- R6: In running mode, a frame ended with 2 to 9 falling edges moves the mode to sleep. A frame ended with 10 or more falling edges stays in running mode.
- R7: In sleep mode, a `cs_n` fall moves the mode to waking on the next clock.
- R8: In waking mode, a frame ended with fewer than 10 falling edges returns the mode to sleep. A frame ended with 10 or more falling edges moves it to running.
- R9: `data_valid` is 1 during a frame that began in running mode. It is 0 during a frame that began in sleep mode, and 0 outside frames.
- R10: `sclk` activity while `cs_n` is high changes neither the mode nor the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the host signals |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample | input | 12 | Parallel sample word standing in for the converter result |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the serial data pad (0 = three-state) |
| mode | output | 2 | Power mode: 00 running, 01 sleep, 10 waking |
| data_valid | output | 1 | Current frame carries a valid result |

## Verification
A wrong falling-edge count shows up at the ports as a mode decision landing on the wrong side of the 2-edge or 10-edge boundary. This becomes visible on `mode` one clock after `cs_n` rises. A corrupted shift register or capture shows as a wrong `sdata` bit within one clock of the `sclk` edge that exposes it. A stale frame-active or valid flag shows on `sdata_oe` or `data_valid` at the clock after the select edge. The bench's cycle model compares all four outputs on every clock. The frame list probes both boundaries from each mode.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_WAKE  = 2'b10
  } sas_mode_e;
endpackage

// File: rtl/sas_front.sv
// Reset synchroniser plus edge detection of the host select and serial clock.
module sas_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic rst_n_sync,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall
);
  logic [1:0] rst_pipe;
  logic       cs_q;
  logic       sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  // only edges inside an already-open frame count (R10)
  assign sclk_fall = sclk_q & ~sclk & ~cs_n & ~cs_q;
endmodule

// File: rtl/sas_shifter.sv
// Frame register, falling-edge counter and output drive.
module sas_shifter #(
  parameter int SAMPLE_W = 12,
  parameter int LEAD_W   = 4,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_fall,
  input  logic                cs_rise,
  input  logic                sclk_fall,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                sdata,
  output logic                sdata_oe,
  output logic [CNT_W-1:0]    fall_cnt
);
  localparam int FRAME_W = SAMPLE_W + LEAD_W;

  logic               active_q, active_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    if (cs_fall) begin
      active_d = 1'b1;
      sh_d     = {{LEAD_W{1'b0}}, sample};   // R3 capture
      cnt_d    = '0;
    end else if (cs_rise) begin
      active_d = 1'b0;
    end else if (sclk_fall && active_q) begin
      sh_d = {sh_q[FRAME_W-2:0], 1'b0};
      if (cnt_q != {CNT_W{1'b1}}) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
    end
  end

  assign sdata    = active_q & sh_q[FRAME_W-1];
  assign sdata_oe = active_q;
  assign fall_cnt = cnt_q;
endmodule

// File: rtl/sas_mode_fsm.sv
// Power mode decision taken when the select returns high.
module sas_mode_fsm
  import sas_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int DOWN_MIN = 2,
  parameter int WAKE_MIN = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic [CNT_W-1:0] fall_cnt,
  output sas_mode_e        mode,
  output logic             data_valid
);
  localparam logic [CNT_W-1:0] DOWN_C = CNT_W'(DOWN_MIN);
  localparam logic [CNT_W-1:0] WAKE_C = CNT_W'(WAKE_MIN);

  sas_mode_e mode_q, mode_d;
  logic      valid_q, valid_d;

  always_comb begin
    mode_d  = mode_q;
    valid_d = valid_q;
    if (cs_fall) valid_d = (mode_q == MODE_RUN);
    else if (cs_rise) valid_d = 1'b0;
    case (mode_q)
      MODE_RUN: begin
        if (cs_rise && fall_cnt >= DOWN_C && fall_cnt < WAKE_C) mode_d = MODE_SLEEP;
      end
      MODE_SLEEP: begin
        if (cs_fall) mode_d = MODE_WAKE;
      end
      MODE_WAKE: begin
        if (cs_rise) mode_d = (fall_cnt >= WAKE_C) ? MODE_RUN : MODE_SLEEP;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RUN;
      valid_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      valid_q <= valid_d;
    end
  end

  assign mode       = mode_q;
  assign data_valid = valid_q;
endmodule

// File: rtl/serial_adc_slave.sv
module serial_adc_slave #(
  parameter int SAMPLE_W = 12,
  parameter int LEAD_W   = 4,
  parameter int DOWN_MIN = 2,
  parameter int WAKE_MIN = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                sdata,
  output logic                sdata_oe,
  output logic [1:0]          mode,
  output logic                data_valid
);
  localparam int FRAME_W = SAMPLE_W + LEAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;

  logic             rst_n_sync, cs_fall, cs_rise, sclk_fall;
  logic [CNT_W-1:0] fall_cnt;
  sas_pkg::sas_mode_e mode_e;

  sas_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .rst_n_sync(rst_n_sync), .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall)
  );

  sas_shifter #(.SAMPLE_W(SAMPLE_W), .LEAD_W(LEAD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n_sync), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sample(sample), .sdata(sdata), .sdata_oe(sdata_oe),
    .fall_cnt(fall_cnt)
  );

  sas_mode_fsm #(.CNT_W(CNT_W), .DOWN_MIN(DOWN_MIN), .WAKE_MIN(WAKE_MIN)) u_fsm (
    .clk(clk), .rst_n(rst_n_sync), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .fall_cnt(fall_cnt), .mode(mode_e), .data_valid(data_valid)
  );

  assign mode = mode_e;
endmodule

// File: rtl/sas_checker.sv
module sas_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sdata,
  input logic       sdata_oe,
  input logic [1:0] mode,
  input logic       data_valid
);
  a_r1_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> (sdata_oe && !sdata));

  a_r2_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !sdata_oe);

  a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  a_r7_wake_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && mode == 2'b01) |=> mode == 2'b10);

  a_r9_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> sdata_oe);

  a_r10_idle_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> $stable(mode));
endmodule

bind serial_adc_slave sas_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdata(sdata),
  .sdata_oe(sdata_oe), .mode(mode), .data_valid(data_valid)
);

// File: tb/serial_adc_slave_bench.sv
module serial_adc_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic        sclk;
  logic [11:0] sample;
  logic        sdata, sdata_oe, data_valid;
  logic [1:0]  mode;

  always #5 clk = ~clk;

  serial_adc_slave u_serial_adc_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
    .sdata(sdata), .sdata_oe(sdata_oe), .mode(mode), .data_valid(data_valid)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode, m_cnt;
  bit m_act, m_val, pcs, psclk;
  bit q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_act = 0; m_val = 0; pcs = 1; psclk = 1;
      q.delete();
    end else begin
      if (pcs && !cs_n) begin
        m_act = 1;
        m_val = (m_mode == 0);
        if (m_mode == 1) m_mode = 2;
        m_cnt = 0;
        q.delete();
        repeat (4) q.push_back(1'b0);
        for (int i = 11; i >= 0; i--) q.push_back(sample[i]);
      end else if (!pcs && cs_n) begin
        if (m_mode == 0 && m_cnt >= 2 && m_cnt < 10) m_mode = 1;
        else if (m_mode == 2) m_mode = (m_cnt >= 10) ? 0 : 1;
        m_act = 0;
        m_val = 0;
      end else if (m_act && !cs_n && psclk && !sclk) begin
        m_cnt++;
        if (q.size() > 0) void'(q.pop_front());
      end
      pcs = cs_n;
      psclk = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1/R3 sdata", sdata, (m_act && q.size() > 0) ? q[0] : 1'b0);
      check("R2 sdata_oe", sdata_oe, m_act);
      check("R4 mode", mode, m_mode);
      check("R9 data_valid", data_valid, m_val);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [1:0] mid_mode;
  logic       mid_valid;

  task automatic frame(input logic [11:0] s, input int nf);
    sample = s;
    cs_n = 1'b0;
    wait_clk(2);
    mid_mode  = mode;
    mid_valid = data_valid;
    sample = ~s;  // R3: change after capture
    for (int k = 0; k < nf; k++) begin
      sclk = 1'b1; wait_clk(3);
      sclk = 1'b0; wait_clk(3);
    end
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sample = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R4 reset mode", mode, 2'b00);
    check("R4 reset oe", sdata_oe, 1'b0);
    check("R4 reset valid", data_valid, 1'b0);

    frame(12'hA5C, 16);
    check("R9 valid in run frame", mid_valid, 1'b1);
    check("R1 full frame keeps run", mode, 2'b00);
    frame(12'h3F1, 1);
    check("R5 one edge keeps run", mode, 2'b00);
    frame(12'h0F0, 0);
    check("R5 zero edges keeps run", mode, 2'b00);
    frame(12'h801, 10);
    check("R6 ten edges keeps run", mode, 2'b00);
    frame(12'hFFF, 2);
    check("R6 two edges sleeps", mode, 2'b01);
    check("R2 oe off after abort", sdata_oe, 1'b0);

    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; wait_clk(3);
      sclk = 1'b0; wait_clk(3);
    end
    check("R10 idle sclk mode", mode, 2'b01);
    check("R10 idle sclk data", {sdata_oe, sdata}, 2'b00);

    frame(12'h123, 8);
    check("R7 waking during frame", mid_mode, 2'b10);
    check("R9 invalid wake frame", mid_valid, 1'b0);
    check("R8 eight edges back to sleep", mode, 2'b01);
    frame(12'h456, 16);
    check("R8 full wake to run", mode, 2'b00);
    check("R9 wake frame invalid", mid_valid, 1'b0);
    frame(12'h789, 16);
    check("R9 next frame valid", mid_valid, 1'b1);
    frame(12'hABC, 9);
    check("R6 nine edges sleeps", mode, 2'b01);
    frame(12'hDEF, 10);
    check("R8 ten edges wake to run", mode, 2'b00);
    frame(12'h5A5, 12);
    check("R9 valid after wake", mid_valid, 1'b1);
    check("R6 twelve edges keeps run", mode, 2'b00);

    done = 1'b1;
    finish_run();
  end
endmodule